// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block is a synchronous state machine that follows the chip power mode and drives the clock-gate and regulator controls. It covers seven modes: two run modes (normal and very-low-power), two wait modes, and three stop modes (normal, very-low-power and low-leakage). The inputs are a wait-for-interrupt pulse from the core, a deep-sleep select, a run-mode select, a stop-mode select and the current clock-generator mode. The outputs are clock enables for the core, for the general peripherals, for the always-on peripherals and for the optional peripherals. The block also drives a regulator low-power request, a low-voltage-detect enable, an interrupt-controller enable and a 3-bit mode code.

Each mode has its own wake path. Wait modes wake on any pending interrupt. Normal and very-low-power stop wake on the asynchronous wake line. Low-leakage stop wakes only on a request from the dedicated wake unit. When a wait or stop mode ends, the block returns to the run mode from which it was entered.

Top module: `lpm_seq`

## Requirements
- R1: After reset, mode_code is 0 (normal run), and core_clk_en, periph_clk_en, lvd_en and nvic_en are 1, with reg_lp_req at 0.
- R2: A wfi pulse in normal run with deep_sel=0 enters normal wait (code 1) on the next cycle. In that mode core_clk_en is 0, while periph_clk_en and nvic_en stay 1. The mode holds until irq_pend is 1, and irq_pend returns the block to run.
- R3: A wfi pulse with deep_sel=1 and stop_sel equal to 0 or 3 enters normal stop (code 2). In that mode periph_clk_en, aon_clk_en and nvic_en are 0 and lvd_en stays 1. Only async_wake exits the mode, and irq_pend alone has no effect.
- R4: In normal run, run_sel=1 enters very-low-power run (code 3) on the next cycle, but only when clk_mode is 1 (slow internal) or 2 (external). With clk_mode 0 or 3 the request is refused and the block stays in code 0. In code 3, reg_lp_req is 1 and lvd_en is 0.
- R5: A wfi pulse in very-low-power run with deep_sel=0 enters very-low-power wait (code 4). In that mode core_clk_en is 0, nvic_en is 1 and reg_lp_req is 1.
- R6: stop_sel=1 with deep_sel=1 enters very-low-power stop (code 5). In that mode periph_clk_en, nvic_en and lvd_en are 0 and aon_clk_en is 4'hF (bit 0 oscillator, bit 1 low-power timer, bit 2 RTC, bit 3 comparator). Each bit of opt_clk_en (bit 0 UART, bit 1 low-power UART, bit 2 timer) equals the matching bit of src_en.
- R7: stop_sel=2 with deep_sel=1 enters low-leakage stop (code 6). In that mode nvic_en is 0, opt_clk_en is 0 and aon_clk_en is 4'hF. Only wu_req exits the mode, and irq_pend and async_wake are ignored.
- R8: Leaving any wait or stop mode goes to code 3 if that mode was entered from very-low-power run, and to code 0 otherwise.
- R9: run_sel is ignored while in a wait or stop mode.
- R10: When run_sel drops to 0 in very-low-power run, reg_lp_req falls on the next cycle while mode_code still reads 3. mode_code changes to 0 one cycle later.
- R11: A wfi pulse is ignored, and the block stays in its run mode, if irq_pend, async_wake or wu_req is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wfi | input | 1 | Wait-for-interrupt pulse from the core |
| deep_sel | input | 1 | 1 selects a stop mode on wfi, 0 selects a wait mode |
| run_sel | input | 1 | 0 normal run, 1 very-low-power run |
| stop_sel | input | 2 | 0/3 normal stop, 1 very-low-power stop, 2 low-leakage stop |
| clk_mode | input | 2 | Clock-generator mode: 0 fast internal, 1 slow internal, 2 external, 3 locked loop |
| irq_pend | input | 1 | Enabled interrupt pending |
| async_wake | input | 1 | Asynchronous wake controller request |
| wu_req | input | 1 | Dedicated wake-unit request |
| src_en | input | 3 | Clock-source enables for UART, low-power UART, timer |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | General peripheral clock enable |
| aon_clk_en | output | 4 | Oscillator, low-power timer, RTC, comparator clock enables |
| opt_clk_en | output | 3 | UART, low-power UART, timer clock enables |
| reg_lp_req | output | 1 | Regulator low-power request |
| lvd_en | output | 1 | Low-voltage-detect enable |
| nvic_en | output | 1 | Interrupt controller enable |
| mode_code | output | 3 | Current mode, 0 to 6 |

## Verification
The assertions check the hold conditions on every cycle. They confirm that normal stop does not leave without async_wake, that low-leakage stop does not leave without wu_req, and that normal wait holds until an interrupt arrives. They also confirm that the clock-mode gate on very-low-power run entry is respected, that a blocked wfi never leaves run, and that the regulator drop is followed by normal run. Only the bench scenarios can show the per-mode output values and the choice of return mode after a wake. They also show the gating of optional clocks by their source enables and the one-cycle ordering of the regulator and mode code.

// File: rtl/lpm_seq.sv
module lpm_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wfi,
  input  logic       deep_sel,
  input  logic       run_sel,
  input  logic [1:0] stop_sel,
  input  logic [1:0] clk_mode,
  input  logic       irq_pend,
  input  logic       async_wake,
  input  logic       wu_req,
  input  logic [2:0] src_en,
  output logic       core_clk_en,
  output logic       periph_clk_en,
  output logic [3:0] aon_clk_en,
  output logic [2:0] opt_clk_en,
  output logic       reg_lp_req,
  output logic       lvd_en,
  output logic       nvic_en,
  output logic [2:0] mode_code
);

  typedef enum logic [2:0] {
    S_NRUN = 3'd0, S_NWAIT = 3'd1, S_NSTOP = 3'd2,
    S_VRUN = 3'd3, S_VWAIT = 3'd4, S_VSTOP = 3'd5, S_LLS = 3'd6
  } mode_t;

  mode_t st, nxt, ret_run;
  logic  ret_vlp, nxt_ret, exit_pend, nxt_exit;

  wire wake_any = irq_pend | async_wake | wu_req;
  wire clk_ok   = (clk_mode == 2'd1) || (clk_mode == 2'd2);
  wire in_run   = (st == S_NRUN) || (st == S_VRUN);
  wire in_vlp   = (st == S_VRUN) || (st == S_VWAIT) || (st == S_VSTOP) || (st == S_LLS);

  assign ret_run = ret_vlp ? S_VRUN : S_NRUN;

  always_comb begin
    nxt      = st;
    nxt_ret  = ret_vlp;
    nxt_exit = 1'b0;
    case (st)
      S_NRUN, S_VRUN: begin
        if (st == S_VRUN && exit_pend)
          nxt = S_NRUN;
        else if (st == S_VRUN && !run_sel)
          nxt_exit = 1'b1;
        else if (wfi && !wake_any) begin
          nxt_ret = (st == S_VRUN);
          if (!deep_sel)
            nxt = (st == S_VRUN) ? S_VWAIT : S_NWAIT;
          else begin
            case (stop_sel)
              2'd1:    nxt = S_VSTOP;
              2'd2:    nxt = S_LLS;
              default: nxt = S_NSTOP;
            endcase
          end
        end else if (st == S_NRUN && run_sel && clk_ok)
          nxt = S_VRUN;
      end
      S_NWAIT, S_VWAIT: if (irq_pend)   nxt = ret_run;
      S_NSTOP, S_VSTOP: if (async_wake) nxt = ret_run;
      S_LLS:            if (wu_req)     nxt = ret_run;
      default:          nxt = S_NRUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_NRUN;
      ret_vlp   <= 1'b0;
      exit_pend <= 1'b0;
    end else begin
      st        <= nxt;
      ret_vlp   <= nxt_ret;
      exit_pend <= nxt_exit;
    end
  end

  wire periph_on = in_run || (st == S_NWAIT) || (st == S_VWAIT);

  assign mode_code     = st;
  assign core_clk_en   = in_run;
  assign periph_clk_en = periph_on;
  assign nvic_en       = periph_on;
  assign aon_clk_en    = {4{periph_on || (st == S_VSTOP) || (st == S_LLS)}};
  assign opt_clk_en    = {3{periph_on}} | ({3{st == S_VSTOP}} & src_en);
  assign reg_lp_req    = in_vlp && !exit_pend;
  assign lvd_en        = !in_vlp;

  assert_nstop_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd2 && !async_wake) |=> (mode_code == 3'd2));

  assert_lls_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd6 && !wu_req) |=> (mode_code == 3'd6));

  assert_nwait_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd1 && !irq_pend) |=> (mode_code == 3'd1));

  assert_vlpr_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd0 && !(clk_mode == 2'd1 || clk_mode == 2'd2)) |=> (mode_code != 3'd3));

  assert_wfi_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd0 && wfi && (irq_pend || async_wake || wu_req)) |=>
      (mode_code == 3'd0 || mode_code == 3'd3));

  assert_reg_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd3 && !reg_lp_req) |=> (mode_code == 3'd0));

endmodule

// File: tb/lpm_seq_tb.sv
module lpm_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wfi = 0, deep_sel = 0, run_sel = 0, irq_pend = 0, async_wake = 0, wu_req = 0;
  logic [1:0] stop_sel = 0, clk_mode = 0;
  logic [2:0] src_en = 0;
  logic core_clk_en, periph_clk_en, reg_lp_req, lvd_en, nvic_en;
  logic [3:0] aon_clk_en;
  logic [2:0] opt_clk_en, mode_code;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lpm_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wfi(wfi), .deep_sel(deep_sel), .run_sel(run_sel),
    .stop_sel(stop_sel), .clk_mode(clk_mode), .irq_pend(irq_pend),
    .async_wake(async_wake), .wu_req(wu_req), .src_en(src_en),
    .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
    .aon_clk_en(aon_clk_en), .opt_clk_en(opt_clk_en), .reg_lp_req(reg_lp_req),
    .lvd_en(lvd_en), .nvic_en(nvic_en), .mode_code(mode_code));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_wfi(logic deep, logic [1:0] ss);
    deep_sel = deep; stop_sel = ss; wfi = 1; tick(); wfi = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; tick(); tick(); rst_n = 1; tick();
    chk("R1 mode", mode_code, 0);
    chk("R1 core", core_clk_en, 1);
    chk("R1 periph", periph_clk_en, 1);
    chk("R1 reglp", reg_lp_req, 0);
    chk("R1 lvd", lvd_en, 1);
    chk("R1 nvic", nvic_en, 1);
  endtask

  task automatic t_nwait();
    pulse_wfi(0, 0);
    chk("R2 mode", mode_code, 1);
    chk("R2 core", core_clk_en, 0);
    chk("R2 periph", periph_clk_en, 1);
    chk("R2 nvic", nvic_en, 1);
    tick();
    chk("R2 hold", mode_code, 1);
    irq_pend = 1; tick(); irq_pend = 0;
    chk("R2 wake R8", mode_code, 0);
  endtask

  task automatic t_nstop();
    pulse_wfi(1, 0);
    chk("R3 mode", mode_code, 2);
    chk("R3 periph", periph_clk_en, 0);
    chk("R3 aon", aon_clk_en, 0);
    chk("R3 nvic", nvic_en, 0);
    chk("R3 lvd", lvd_en, 1);
    irq_pend = 1; tick(); irq_pend = 0;
    chk("R3 irq ignored", mode_code, 2);
    async_wake = 1; tick(); async_wake = 0;
    chk("R3 wake", mode_code, 0);
    pulse_wfi(1, 3);
    chk("R3 sel3", mode_code, 2);
    async_wake = 1; tick(); async_wake = 0;
  endtask

  task automatic t_vlpr_entry();
    run_sel = 1; clk_mode = 0; tick();
    chk("R4 refuse0", mode_code, 0);
    clk_mode = 3; tick();
    chk("R4 refuse3", mode_code, 0);
    clk_mode = 1; tick();
    chk("R4 enter", mode_code, 3);
    chk("R4 reglp", reg_lp_req, 1);
    chk("R4 lvd", lvd_en, 0);
    chk("R4 core", core_clk_en, 1);
  endtask

  task automatic t_vwait();
    pulse_wfi(0, 0);
    chk("R5 mode", mode_code, 4);
    chk("R5 core", core_clk_en, 0);
    chk("R5 nvic", nvic_en, 1);
    chk("R5 reglp", reg_lp_req, 1);
    run_sel = 0; tick();
    chk("R9 run_sel ignored", mode_code, 4);
    chk("R9 reglp kept", reg_lp_req, 1);
    run_sel = 1; irq_pend = 1; tick(); irq_pend = 0;
    chk("R8 back to vlpr", mode_code, 3);
  endtask

  task automatic t_vstop();
    src_en = 3'b101;
    pulse_wfi(1, 1);
    chk("R6 mode", mode_code, 5);
    chk("R6 aon", aon_clk_en, 4'hF);
    chk("R6 opt", opt_clk_en, 3'b101);
    chk("R6 periph", periph_clk_en, 0);
    chk("R6 nvic", nvic_en, 0);
    chk("R6 lvd", lvd_en, 0);
    src_en = 3'b010; #1;
    chk("R6 opt follow", opt_clk_en, 3'b010);
    async_wake = 1; tick(); async_wake = 0;
    chk("R8 vstop exit", mode_code, 3);
  endtask

  task automatic t_lls();
    pulse_wfi(1, 2);
    chk("R7 mode", mode_code, 6);
    chk("R7 nvic", nvic_en, 0);
    chk("R7 opt", opt_clk_en, 0);
    chk("R7 aon", aon_clk_en, 4'hF);
    irq_pend = 1; async_wake = 1; tick(); irq_pend = 0; async_wake = 0;
    chk("R7 ignore", mode_code, 6);
    wu_req = 1; tick(); wu_req = 0;
    chk("R7 R8 exit", mode_code, 3);
  endtask

  task automatic t_vexit();
    run_sel = 0; tick();
    chk("R10 mode held", mode_code, 3);
    chk("R10 reg first", reg_lp_req, 0);
    tick();
    chk("R10 mode", mode_code, 0);
    chk("R10 lvd", lvd_en, 1);
  endtask

  task automatic t_wfi_block();
    irq_pend = 1; pulse_wfi(0, 0); irq_pend = 0;
    chk("R11 irq", mode_code, 0);
    async_wake = 1; pulse_wfi(1, 0); async_wake = 0;
    chk("R11 async", mode_code, 0);
    wu_req = 1; pulse_wfi(1, 2); wu_req = 0;
    chk("R11 wu", mode_code, 0);
    pulse_wfi(1, 1);
    chk("R8 vstop from nrun", mode_code, 5);
    async_wake = 1; tick(); async_wake = 0;
    chk("R8 return nrun", mode_code, 0);
  endtask

  initial begin
    t_reset();
    t_nwait();
    t_nstop();
    t_vlpr_entry();
    t_vwait();
    t_vstop();
    t_lls();
    t_vexit();
    t_wfi_block();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule